// File: doc/BRIEF.md
# MESI Snoop Control Unit

This unit keeps the private data caches of several cores coherent under the four-state MESI protocol. It holds a duplicate copy of every core's cache tags and line states. Each core sends it read misses, write misses or upgrades, and evictions. For every request the unit looks up the duplicate tags of all other cores. It sends coherency commands only to cores that really hold the line. It also moves the line from a peer cache to the requester, whether that line is clean or dirty. Memory is used only when no peer holds the line, or when a dirty line is evicted.

Requests are taken one at a time and chosen round-robin. A transaction runs from acceptance, through lookup, then snoops and/or a memory access, to the response. At that point every affected duplicate entry is updated. Requests, snoop commands, memory requests and responses all use valid/ready. A sender raises valid and then keeps valid and its payload unchanged until the cycle in which ready is also high. Any receiver may hold ready low for any number of cycles. The data arrays and memory sit outside this block. Line data moves beside it and is not carried on its ports.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: Line states are encoded I=0, S=1, E=2, M=3. At lookup, a line held in E or M by any core is held by no other core.
- R2: A read (op code 0) that no other core holds issues one memory read (mem_req_wr=0) and answers E with source memory (source code 1).
- R3: A snoop command is sent only to a core other than the requester whose duplicate tags hold the line in a valid state.
- R4: A read of a line held clean by others sends forward-and-share (snoop code 2) to the lowest-numbered holder only. It answers S with source peer (code 2), names that peer, and makes no memory access. Afterwards all holders are in S.
- R5: A read of a line held M by another core sends forward-and-invalidate (snoop code 3) to that owner. It answers M from that peer with no memory access at all, so there is no write-back. The owner ends in I.
- R6: A write (op code 1) from a core without the line invalidates every other holder (snoop code 1). One supplier is chosen: the M owner if there is one, otherwise the lowest-numbered holder. The supplier gets code 3 instead and is named as the peer. With no holder, one memory read supplies the line. The answer is always M.
- R7: A write from a core that already holds the line is an upgrade. It invalidates the other holders with code 1, answers M with source none (code 0), and makes no memory access.
- R8: An eviction (op code 2) answers I with source none. It issues one memory write (mem_req_wr=1) only if the line was M, and its duplicate entry becomes I.
- R9: The duplicate entries of the requester and of every snooped core take their new states when the response is taken. Later requests are filtered by those new states.
- R10: Requests are granted round-robin. After reset core 0 has first priority. After a grant, priority starts at the next core in cyclic order.
- R11: Only one transaction is in progress. No request is accepted from the cycle a request is accepted until its response has been taken.
- R12: snp_valid, mem_req_valid and rsp_valid, with their payloads, stay unchanged while the matching ready is low.
- R13: After reset all duplicate entries are I, and no snoop, memory request or response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NC | Per-core request valid |
| req_ready | output | NC | Per-core request accepted |
| req_op | input | 2*NC | Per-core op: 0 read, 1 write/upgrade, 2 evict (3 acts as read) |
| req_addr | input | AW*NC | Per-core line address; the low log2(SETS) bits select the set |
| rsp_valid | output | NC | Response valid to the requester |
| rsp_ready | input | NC | Per-core response ready |
| rsp_state | output | 2 | Granted line state |
| rsp_src | output | 2 | Data source: 0 none, 1 memory, 2 peer cache |
| rsp_peer | output | log2(NC) | Supplying core when source is peer |
| snp_valid | output | NC | Per-core snoop command valid |
| snp_ready | input | NC | Per-core snoop command taken |
| snp_cmd | output | 2*NC | Per-core command: 1 invalidate, 2 forward and share, 3 forward and invalidate |
| snp_addr | output | AW | Line address of the snoop |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_wr | output | 1 | 1 write-back, 0 line read |
| mem_req_addr | output | AW | Memory line address |
| mem_rsp_valid | input | 1 | Read data returned (one-cycle pulse) |

## Verification
The bench builds the unit with four cores, 16 sets and a 12-bit line address. With four cores it can form a line shared by three readers, then have the fourth core take ownership of it by invalidating all three. It can also pass a dirty line back and forth, and send round-robin priority around a wrap past the last core. Ready lines toggle on the snoop, response and memory sides, so every handshake runs under back-pressure.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_EVICT = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {SNP_NOP = 2'd0, SNP_INV = 2'd1, SNP_FWD_S = 2'd2, SNP_FWD_INV = 2'd3} snp_e;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_MEM = 2'd1, SRC_PEER = 2'd2, SRC_RSVD = 2'd3} src_e;
  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_SNOOP, F_MEMREQ, F_MEMWAIT, F_RESP} fsm_e;
endpackage

// File: rtl/msc_rr_arb.sv
module msc_rr_arb #(
  parameter int NC = 4,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NC-1:0] req,
  output logic [NC-1:0] gnt,
  output logic [CW-1:0] gnt_idx
);
  logic [CW-1:0] ptr_q;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < NC; k++) begin
      int c;
      c = (int'(ptr_q) + k) % NC;
      if (!found && req[c]) begin
        found   = 1'b1;
        gnt[c]  = en;
        gnt_idx = CW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (en && found) ptr_q <= (gnt_idx == CW'(NC - 1)) ? '0 : gnt_idx + 1'b1;
  end

  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
endmodule

// File: rtl/msc_tag_store.sv
module msc_tag_store
  import msc_pkg::*;
#(
  parameter int AW   = 12,
  parameter int SETS = 16,
  localparam int IW = $clog2(SETS),
  localparam int TW = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  output mesi_e         lk_state,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  mesi_e         wr_state
);
  logic [TW-1:0] tag_q [SETS];
  mesi_e         st_q  [SETS];
  logic [IW-1:0] lk_idx, wr_idx;

  assign lk_idx = lk_addr[IW-1:0];
  assign wr_idx = wr_addr[IW-1:0];
  assign lk_state = (st_q[lk_idx] != ST_I && tag_q[lk_idx] == lk_addr[AW-1:IW]) ? st_q[lk_idx] : ST_I;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        st_q[s]  <= ST_I;
        tag_q[s] <= '0;
      end
    end else if (we) begin
      st_q[wr_idx]  <= wr_state;
      tag_q[wr_idx] <= wr_addr[AW-1:IW];
    end
  end
endmodule

// File: rtl/msc_plan.sv
module msc_plan
  import msc_pkg::*;
#(
  parameter int NC = 4,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  op_e           op,
  input  logic [CW-1:0] rq,
  input  mesi_e         hit     [NC],
  output logic [NC-1:0] snp_mask,
  output snp_e          snp_cmd [NC],
  output logic          mem_rd,
  output logic          mem_wr,
  output mesi_e         rsp_state,
  output src_e          rsp_src,
  output logic [CW-1:0] rsp_peer,
  output logic [NC-1:0] upd,
  output mesi_e         new_st  [NC]
);
  logic [NC-1:0] holders;
  logic          has_m, found;
  logic [CW-1:0] m_idx, low_idx, sup;
  mesi_e         own;

  always_comb begin
    holders = '0;
    has_m   = 1'b0;
    found   = 1'b0;
    m_idx   = '0;
    low_idx = '0;
    own     = hit[rq];
    for (int c = 0; c < NC; c++) begin
      if (c != int'(rq) && hit[c] != ST_I) begin
        holders[c] = 1'b1;
        if (!found) begin
          found   = 1'b1;
          low_idx = CW'(c);
        end
        if (hit[c] == ST_M) begin
          has_m = 1'b1;
          m_idx = CW'(c);
        end
      end
    end
    sup = has_m ? m_idx : low_idx;
  end

  always_comb begin
    snp_mask  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    rsp_state = ST_I;
    rsp_src   = SRC_NONE;
    rsp_peer  = '0;
    upd       = '0;
    for (int c = 0; c < NC; c++) begin
      snp_cmd[c] = SNP_NOP;
      new_st[c]  = ST_I;
    end
    upd[rq] = 1'b1;
    case (op)
      OP_WRITE: begin
        rsp_state = ST_M;
        for (int c = 0; c < NC; c++) begin
          if (holders[c]) begin
            snp_mask[c] = 1'b1;
            snp_cmd[c]  = SNP_INV;
            upd[c]      = 1'b1;
          end
        end
        if (own != ST_I) begin
          rsp_src = SRC_NONE;
        end else if (found) begin
          snp_cmd[sup] = SNP_FWD_INV;
          rsp_src      = SRC_PEER;
          rsp_peer     = sup;
        end else begin
          mem_rd  = 1'b1;
          rsp_src = SRC_MEM;
        end
        new_st[rq] = ST_M;
      end
      OP_EVICT: begin
        mem_wr     = (own == ST_M);
        new_st[rq] = ST_I;
      end
      default: begin
        if (!found) begin
          mem_rd    = 1'b1;
          rsp_state = ST_E;
          rsp_src   = SRC_MEM;
        end else if (has_m) begin
          snp_mask[sup] = 1'b1;
          snp_cmd[sup]  = SNP_FWD_INV;
          upd[sup]      = 1'b1;
          rsp_state     = ST_M;
          rsp_src       = SRC_PEER;
          rsp_peer      = sup;
        end else begin
          snp_mask[sup] = 1'b1;
          snp_cmd[sup]  = SNP_FWD_S;
          for (int c = 0; c < NC; c++) begin
            if (holders[c]) begin
              upd[c]    = 1'b1;
              new_st[c] = ST_S;
            end
          end
          rsp_state = ST_S;
          rsp_src   = SRC_PEER;
          rsp_peer  = sup;
        end
        new_st[rq] = rsp_state;
      end
    endcase
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import msc_pkg::*;
#(
  parameter int NC   = 4,
  parameter int AW   = 12,
  parameter int SETS = 16,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    req_valid,
  output logic [NC-1:0]    req_ready,
  input  logic [2*NC-1:0]  req_op,
  input  logic [AW*NC-1:0] req_addr,
  output logic [NC-1:0]    rsp_valid,
  input  logic [NC-1:0]    rsp_ready,
  output logic [1:0]       rsp_state,
  output logic [1:0]       rsp_src,
  output logic [CW-1:0]    rsp_peer,
  output logic [NC-1:0]    snp_valid,
  input  logic [NC-1:0]    snp_ready,
  output logic [2*NC-1:0]  snp_cmd,
  output logic [AW-1:0]    snp_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_wr,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid
);
  fsm_e          state_q;
  logic [CW-1:0] rq_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [NC-1:0] pend_q, upd_q;
  snp_e          cmd_q [NC];
  mesi_e         new_q [NC];
  logic          mem_rd_q, mem_wr_q;
  mesi_e         rst_q;
  src_e          src_q;
  logic [CW-1:0] peer_q;

  logic [NC-1:0] gnt;
  logic [CW-1:0] gnt_idx;
  mesi_e         hit [NC];
  logic [NC-1:0] p_mask, p_upd;
  snp_e          p_cmd [NC];
  mesi_e         p_new [NC];
  logic          p_rd, p_wr;
  mesi_e         p_state;
  src_e          p_src;
  logic [CW-1:0] p_peer;
  logic          rsp_take;
  logic [NC-1:0] pend_left;

  msc_rr_arb #(.NC(NC)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(state_q == F_IDLE),
    .req(req_valid), .gnt(gnt), .gnt_idx(gnt_idx)
  );

  assign rsp_take = (state_q == F_RESP) && rsp_ready[rq_q];

  for (genvar g = 0; g < NC; g++) begin : g_core
    msc_tag_store #(.AW(AW), .SETS(SETS)) u_tags (
      .clk(clk), .rst_n(rst_n), .lk_addr(addr_q), .lk_state(hit[g]),
      .we(rsp_take && upd_q[g]), .wr_addr(addr_q), .wr_state(new_q[g])
    );
    assign snp_cmd[2*g +: 2] = cmd_q[g];

    // R3
    snp_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid[g] |-> (hit[g] != ST_I && g != int'(rq_q)));
    // R12
    snp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid[g] && !snp_ready[g] |=> snp_valid[g] && $stable(snp_cmd[2*g +: 2]) && $stable(snp_addr));
  end

  msc_plan #(.NC(NC)) u_plan (
    .op(op_q), .rq(rq_q), .hit(hit), .snp_mask(p_mask), .snp_cmd(p_cmd),
    .mem_rd(p_rd), .mem_wr(p_wr), .rsp_state(p_state), .rsp_src(p_src),
    .rsp_peer(p_peer), .upd(p_upd), .new_st(p_new)
  );

  assign req_ready     = gnt;
  assign pend_left     = pend_q & ~snp_ready;
  assign snp_valid     = (state_q == F_SNOOP) ? pend_q : '0;
  assign snp_addr      = addr_q;
  assign mem_req_valid = (state_q == F_MEMREQ);
  assign mem_req_wr    = mem_wr_q;
  assign mem_req_addr  = addr_q;
  assign rsp_state     = rst_q;
  assign rsp_src       = src_q;
  assign rsp_peer      = peer_q;

  always_comb begin
    rsp_valid = '0;
    if (state_q == F_RESP) rsp_valid[rq_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= F_IDLE;
      rq_q     <= '0;
      op_q     <= OP_READ;
      addr_q   <= '0;
      pend_q   <= '0;
      upd_q    <= '0;
      mem_rd_q <= 1'b0;
      mem_wr_q <= 1'b0;
      rst_q    <= ST_I;
      src_q    <= SRC_NONE;
      peer_q   <= '0;
      for (int c = 0; c < NC; c++) begin
        cmd_q[c] <= SNP_NOP;
        new_q[c] <= ST_I;
      end
    end else begin
      case (state_q)
        F_IDLE: if (|gnt) begin
          rq_q    <= gnt_idx;
          op_q    <= op_e'(req_op[2*gnt_idx +: 2]);
          addr_q  <= req_addr[AW*gnt_idx +: AW];
          state_q <= F_LOOK;
        end
        F_LOOK: begin
          pend_q   <= p_mask;
          upd_q    <= p_upd;
          mem_rd_q <= p_rd;
          mem_wr_q <= p_wr;
          rst_q    <= p_state;
          src_q    <= p_src;
          peer_q   <= p_peer;
          for (int c = 0; c < NC; c++) begin
            cmd_q[c] <= p_cmd[c];
            new_q[c] <= p_new[c];
          end
          if (|p_mask)          state_q <= F_SNOOP;
          else if (p_rd || p_wr) state_q <= F_MEMREQ;
          else                  state_q <= F_RESP;
        end
        F_SNOOP: begin
          pend_q <= pend_left;
          if (pend_left == '0) state_q <= (mem_rd_q || mem_wr_q) ? F_MEMREQ : F_RESP;
        end
        F_MEMREQ: if (mem_req_ready) state_q <= mem_wr_q ? F_RESP : F_MEMWAIT;
        F_MEMWAIT: if (mem_rsp_valid) state_q <= F_RESP;
        F_RESP: if (rsp_take) state_q <= F_IDLE;
        default: state_q <= F_IDLE;
      endcase
    end
  end

  logic [CW:0] n_own, n_hold;
  always_comb begin
    n_own  = '0;
    n_hold = '0;
    for (int c = 0; c < NC; c++) begin
      if (hit[c] == ST_E || hit[c] == ST_M) n_own = n_own + 1'b1;
      if (hit[c] != ST_I) n_hold = n_hold + 1'b1;
    end
  end

  // R1
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == F_LOOK) |-> (n_own == '0 || n_hold == (CW+1)'(1)));
  // R11
  one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> !(|req_ready));
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wr));
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rsp_valid & ~rsp_ready)) |=> $stable(rsp_valid) && $stable(rsp_state) && $stable(rsp_src));
  // R13
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rsp_valid));
endmodule

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
  localparam int NC = 4, AW = 12, SETS = 16, CW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [NC-1:0] req_valid, req_ready, rsp_valid, rsp_ready, snp_valid, snp_ready;
  logic [2*NC-1:0] req_op, snp_cmd;
  logic [AW*NC-1:0] req_addr;
  logic [1:0] rsp_state, rsp_src;
  logic [CW-1:0] rsp_peer;
  logic [AW-1:0] snp_addr, mem_req_addr;
  logic mem_req_valid, mem_req_ready, mem_req_wr, mem_rsp_valid;

  mesi_snoop_ctrl #(.NC(NC), .AW(AW), .SETS(SETS)) u_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_state(rsp_state), .rsp_src(rsp_src), .rsp_peer(rsp_peer),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_wr(mem_req_wr),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
  );

  int total = 0, bad = 0;
  task automatic chk(bit ok, string rq, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference model: line state per (core, address)
  int mdl [int];
  function automatic int gst(int c, int a);
    int k = c * (1 << AW) + a;
    return mdl.exists(k) ? mdl[k] : 0;
  endfunction

  int p_op [NC], p_addr [NC], done_cnt [NC];
  int e_core, e_mask, e_mem, e_state, e_src, e_peer, e_addr;
  int e_cmd [NC], e_new [NC], e_upd [NC];
  string e_req;
  int seen_mask, seen_mem, mem_cnt;
  bit busy;
  int gq [$];

  function automatic void plan(int r);
    int hold = 0, sup = -1, mown = -1, own;
    e_core = r; e_addr = p_addr[r]; e_mask = 0; e_mem = 0; e_src = 0; e_peer = 0;
    own = gst(r, e_addr);
    for (int c = 0; c < NC; c++) begin
      e_cmd[c] = 0; e_new[c] = 0; e_upd[c] = 0;
      if (c != r && gst(c, e_addr) != 0) begin
        hold |= 1 << c;
        if (sup < 0) sup = c;
        if (gst(c, e_addr) == 3) mown = c;
      end
    end
    if (mown >= 0) sup = mown;
    e_upd[r] = 1;
    if (p_op[r] == 1) begin
      e_state = 3; e_new[r] = 3;
      for (int c = 0; c < NC; c++) if (hold[c]) begin e_mask |= 1 << c; e_cmd[c] = 1; e_upd[c] = 1; end
      if (own != 0) begin e_req = "R7"; end
      else if (hold != 0) begin e_req = "R6"; e_cmd[sup] = 3; e_src = 2; e_peer = sup; end
      else begin e_req = "R6"; e_mem = 1; e_src = 1; end
    end else if (p_op[r] == 2) begin
      e_req = "R8"; e_state = 0; e_new[r] = 0; e_mem = (own == 3) ? 2 : 0;
    end else if (hold == 0) begin
      e_req = "R2"; e_mem = 1; e_state = 2; e_src = 1; e_new[r] = 2;
    end else if (mown >= 0) begin
      e_req = "R5"; e_mask = 1 << sup; e_cmd[sup] = 3; e_upd[sup] = 1; e_new[sup] = 0;
      e_state = 3; e_src = 2; e_peer = sup; e_new[r] = 3;
    end else begin
      e_req = "R4"; e_mask = 1 << sup; e_cmd[sup] = 2;
      for (int c = 0; c < NC; c++) if (hold[c]) begin e_upd[c] = 1; e_new[c] = 1; end
      e_state = 1; e_src = 2; e_peer = sup; e_new[r] = 1;
    end
  endfunction

  // monitor: compares every clock against the model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int c = 0; c < NC; c++) if (req_valid[c] && req_ready[c]) begin
          chk(!busy, "R11", "accept while busy", 1, 0);
          plan(c);
          busy = 1; seen_mask = 0; seen_mem = 0;
          gq.push_back(c);
        end
        if (!busy && (snp_valid != 0 || mem_req_valid || rsp_valid != 0))
          chk(0, "R11", "activity while idle", 1, 0);
        for (int c = 0; c < NC; c++) if (snp_valid[c] && snp_ready[c]) begin
          chk(e_mask[c], "R3", "snoop target", c, e_mask);
          chk(int'(snp_cmd[2*c +: 2]) == e_cmd[c], e_req, "snoop cmd", int'(snp_cmd[2*c +: 2]), e_cmd[c]);
          chk(int'(snp_addr) == e_addr, e_req, "snoop addr", int'(snp_addr), e_addr);
          seen_mask |= 1 << c;
        end
        if (mem_req_valid && mem_req_ready) begin
          seen_mem = mem_req_wr ? 2 : 1;
          chk(seen_mem == e_mem, e_req, "mem op", seen_mem, e_mem);
          chk(int'(mem_req_addr) == e_addr, e_req, "mem addr", int'(mem_req_addr), e_addr);
          if (!mem_req_wr) mem_cnt = 3;
        end
        for (int c = 0; c < NC; c++) if (rsp_valid[c] && rsp_ready[c]) begin
          chk(c == e_core, e_req, "rsp core", c, e_core);
          chk(int'(rsp_state) == e_state, e_req, "rsp state", int'(rsp_state), e_state);
          chk(int'(rsp_src) == e_src, e_req, "rsp src", int'(rsp_src), e_src);
          if (e_src == 2) chk(int'(rsp_peer) == e_peer, e_req, "rsp peer", int'(rsp_peer), e_peer);
          chk(seen_mask == e_mask, "R3", "snooped set", seen_mask, e_mask);
          chk(seen_mem == e_mem, e_req, "mem seen", seen_mem, e_mem);
          for (int k = 0; k < NC; k++) if (e_upd[k]) mdl[k * (1 << AW) + e_addr] = e_new[k];
          busy = 0;
          done_cnt[c]++;
        end
      end
    end
  end

  // ready patterns, memory stub, watchdog
  int cyc = 0;
  initial begin
    snp_ready = '1; rsp_ready = '1; mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_cnt = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      snp_ready = 4'b1101 | 4'((cyc & 1) << 1);
      rsp_ready = 4'b0111 | 4'((cyc & 1) << 3);
      mem_req_ready = cyc[1];
      if (mem_cnt > 0) mem_cnt--;
      mem_rsp_valid = (mem_cnt == 1);
      if (cyc > 100000) begin
        chk(0, "R11", "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic issue(int c, int op, int a);
    int n;
    @(posedge clk); #1;
    p_op[c] = op; p_addr[c] = a;
    req_op[2*c +: 2] = 2'(op);
    req_addr[AW*c +: AW] = AW'(a);
    req_valid[c] = 1'b1;
    n = done_cnt[c];
    do @(negedge clk); while (!req_ready[c]);
    @(posedge clk); #1;
    req_valid[c] = 1'b0;
    wait (done_cnt[c] != n);
  endtask

  localparam int A = 'h011, B = 'h022, C = 'h033, D = 'h044;

  initial begin
    busy = 0;
    for (int c = 0; c < NC; c++) done_cnt[c] = 0;
    req_valid = '0; req_op = '0; req_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R13: nothing valid after reset
    chk(snp_valid == 0, "R13", "snp_valid", int'(snp_valid), 0);
    chk(rsp_valid == 0, "R13", "rsp_valid", int'(rsp_valid), 0);
    chk(mem_req_valid == 0, "R13", "mem_req_valid", int'(mem_req_valid), 0);
    issue(0, 0, A);   // R2 miss to memory, E
    issue(1, 0, A);   // R4 clean forward from core 0
    issue(2, 0, A);   // R4 lowest holder supplies, core 1 not snooped
    issue(3, 1, A);   // R6 three holders invalidated, core 0 supplies
    issue(0, 0, A);   // R5 dirty migration from core 3
    issue(0, 2, A);   // R8 dirty eviction writes back
    issue(1, 0, A);   // R9 filter sees no holder now, memory read
    issue(2, 0, A);   // R4 share with core 1
    issue(2, 1, A);   // R7 upgrade invalidates core 1 only
    issue(2, 2, A);   // R8 dirty eviction
    issue(3, 0, B);   // R2
    issue(3, 2, B);   // R8 clean eviction, no memory access
    issue(1, 1, C);   // R6 write miss with no holder
    // R10 round-robin, priority now at core 2
    gq.delete();
    fork
      issue(0, 0, D);
      issue(1, 0, B);
    join
    chk(gq.size() == 2 && gq[0] == 0 && gq[1] == 1, "R10", "grant order pair 1", gq.size() > 0 ? gq[0] : -1, 0);
    gq.delete();
    fork
      issue(2, 0, D);
      issue(0, 1, C);
    join
    chk(gq.size() == 2 && gq[0] == 2 && gq[1] == 0, "R10", "grant order pair 2", gq.size() > 0 ? gq[0] : -1, 2);
    issue(3, 0, C);   // R9 core 0 now owns C in M
    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule